// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral event sources and from two external request pins. It keeps a pending flag for each internal source and a mask bit for each source group. It gives the CPU a single request line and a 4-bit vector number. The vector number indexes a 14-slot handler table. Slot 0 belongs to reset. Slots 1 and 2 are the external pins. Slots 3 to 8 are timer events. Slot 9 is the serial-peripheral transfer-done event. Slots 10 to 12 are UART events. Slot 13 is the analog comparator. A lower slot number means a higher priority.

A single global enable gates all requests to the CPU. The hardware clears it when the CPU acknowledges an interrupt. A return-from-interrupt strobe sets it again, and software may also set it through the configuration write port, for example to allow nesting. While the global enable is off, internal events stay pending. They are handed out one at a time, highest priority first, after each return. The external pins are level requests: they pass through a synchronizer and count only while the pin is held high.

The CPU core, the vector fetch and the peripherals themselves are outside this block. At the block's edge they appear as simple strobes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Reset drives irq_out low and vector_out to 0, and clears the global enable, every group enable and every pending flag. An event latched before reset does not produce an interrupt after reset.
- R2: A one-cycle pulse on periph_evt bit k latches a pending flag for vector k+3. With the group and the global enable set, irq_out rises two clock edges after the pulse is sampled, and vector_out shows k+3.
- R3: When several enabled sources are pending, vector_out names the lowest-numbered one.
- R4: While irq_out is high and ack is low, vector_out does not change, even if a higher-priority request arrives.
- R5: ack sampled while irq_out is high accepts the shown vector. On that edge irq_out falls, the global enable clears and the pending flag of that vector clears.
- R6: Requests that arrive while the global enable is off produce no irq_out. After each return they are issued one per return, in priority order.
- R7: A reti strobe sets the global enable. A configuration write with bit 0 set also sets it, including inside a handler, which allows nesting.
- R8: ext_irq bit j requests vector j+1 after a two-flop synchronizer, so irq_out rises three edges after the pin rises. The request exists only while the pin is high. If the pin drops before ack, irq_out withdraws three edges later and the request is lost.
- R9: cfg_wdata bit 0 is the global enable. Bits 1 to 5 enable, in order, the external pins, the timers, the transfer-done event, the UART and the comparator. A masked source that is pending raises no irq_out. It is issued once its group is enabled.
- R10: If an event pulse for a vector arrives in the same cycle as the ack of that vector, its pending flag stays set, and the vector is issued again after return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (vector 0, not maskable) |
| ext_irq | input | 2 | Asynchronous level requests from the external pins, bit j is vector j+1 |
| periph_evt | input | 11 | One-cycle peripheral event pulses, bit k is vector k+3 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Bit 0 global enable, bits 5:1 group enables |
| ack | input | 1 | CPU accepts the shown vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the CPU |
| vector_out | output | 4 | Slot number of the requested handler |

## Verification
Every internal source is pulsed on its own. This separates the mapping from periph_evt bits to slot numbers and shows that ack clears only the flag it should. Every ordered pair of internal sources is raised together while the global enable is off. This tells a true lowest-index winner apart from a bit-order or first-come choice, and shows that the loser is still there after return. Each source is also pulsed with only its own group masked, which exposes a wrong group decode. Short directed runs cover the remaining behaviour: a pin that drops before ack, two pins at once, a higher request arriving while a vector is shown, an event that coincides with its own ack, and a nested enable written from inside a handler.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   localparam int NUM_GRP = 5;
   localparam int CFG_W   = NUM_GRP + 1;

   typedef enum logic [2:0] {
      GRP_EXT  = 3'd0,
      GRP_TMR  = 3'd1,
      GRP_SPI  = 3'd2,
      GRP_UART = 3'd3,
      GRP_ACMP = 3'd4
   } grp_e;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irqc_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_pending.sv
`timescale 1ns/1ps
module irqc_pending #(
   parameter int N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   if (N < 1) begin : g_bad_n
      $error("irqc_pending: N must be at least 1");
   end

   logic [N-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | evt;
   end

   assign pend = pend_q;

   for (genvar i = 0; i < N; i++) begin : g_chk
      assert_evt_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pend_q[i]);
      assert_clr_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !pend_q[i]);
   end
endmodule

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter #(
   parameter int VEC_W = 4,
   localparam int SPAN = 1 << VEC_W
) (
   input  logic [SPAN-1:0]  req,
   output logic             any,
   output logic [VEC_W-1:0] win
);
   if (VEC_W < 1) begin : g_bad_w
      $error("irqc_arbiter: VEC_W must be at least 1");
   end

   always_comb begin
      win = '0;
      for (int i = SPAN - 1; i >= 0; i--) begin
         if (req[i]) win = VEC_W'(i);
      end
   end

   assign any = |req;

   logic [SPAN-1:0] below_win;
   assign below_win = (SPAN'(1) << win) - SPAN'(1);

   always_comb begin
      if (any) begin
         assert_win_lowest_R3: assert (req[win] && ((req & below_win) == '0));
      end
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl #(
   parameter int N_EXT       = 2,
   parameter int N_TMR       = 6,
   parameter int N_SPI       = 1,
   parameter int N_UART      = 3,
   parameter int N_ACMP      = 1,
   parameter int SYNC_STAGES = 2,
   localparam int N_INT      = N_TMR + N_SPI + N_UART + N_ACMP,
   localparam int NUM_VEC    = 1 + N_EXT + N_INT,
   localparam int VEC_W      = $clog2(NUM_VEC),
   localparam int CFG_W      = irqc_pkg::CFG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_irq,
   input  logic [N_INT-1:0] periph_evt,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             ack,
   input  logic             reti,
   output logic             irq_out,
   output logic [VEC_W-1:0] vector_out
);
   import irqc_pkg::*;

   localparam int SPAN   = 1 << VEC_W;
   localparam int LAST_E = N_EXT;
   localparam int LAST_T = LAST_E + N_TMR;
   localparam int LAST_S = LAST_T + N_SPI;
   localparam int LAST_U = LAST_S + N_UART;

   if (N_EXT < 1 || N_TMR < 1 || N_SPI < 1 || N_UART < 1 || N_ACMP < 1) begin : g_bad_cnt
      $error("vec_irq_ctrl: every source group needs at least one member");
   end
   if (VEC_W > 8) begin : g_bad_vec
      $error("vec_irq_ctrl: vector table too large");
   end

   // ---------------- configuration state ----------------
   logic               gie_q;
   logic [NUM_GRP-1:0] grp_en_q;
   logic               irq_q;
   logic [VEC_W-1:0]   vec_q;
   logic               accept;

   assign accept = irq_q & ack;

   always_ff @(posedge clk) begin
      if (!rst_n)      gie_q <= 1'b0;
      else if (accept) gie_q <= 1'b0;
      else if (reti)   gie_q <= 1'b1;
      else if (cfg_we) gie_q <= cfg_wdata[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      grp_en_q <= '0;
      else if (cfg_we) grp_en_q <= cfg_wdata[CFG_W-1:1];
   end

   // ---------------- sources ----------------
   logic [N_EXT-1:0] ext_lvl;
   logic [N_INT-1:0] pend;
   logic [N_INT-1:0] clr;

   irqc_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ext_irq),
      .q     (ext_lvl)
   );

   for (genvar i = 0; i < N_INT; i++) begin : g_clr
      assign clr[i] = accept && (vec_q == VEC_W'(i + N_EXT + 1));
   end

   irqc_pending #(.N(N_INT)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (periph_evt),
      .clr   (clr),
      .pend  (pend)
   );

   // ---------------- per-vector request map ----------------
   logic [NUM_VEC-1:1] src_lvl;
   logic [SPAN-1:0]    req;

   assign req[0] = 1'b0;

   for (genvar v = 1; v < NUM_VEC; v++) begin : g_src
      localparam grp_e GRP = (v <= LAST_E) ? GRP_EXT  :
                             (v <= LAST_T) ? GRP_TMR  :
                             (v <= LAST_S) ? GRP_SPI  :
                             (v <= LAST_U) ? GRP_UART : GRP_ACMP;
      if (v <= LAST_E) begin : g_ext
         assign src_lvl[v] = ext_lvl[v-1];
      end else begin : g_int
         assign src_lvl[v] = pend[v-N_EXT-1];
      end
      assign req[v] = src_lvl[v] & grp_en_q[GRP];
   end

   for (genvar u = NUM_VEC; u < SPAN; u++) begin : g_pad
      assign req[u] = 1'b0;
   end

   // ---------------- arbitration and dispatch ----------------
   logic             any;
   logic [VEC_W-1:0] win;

   irqc_arbiter #(.VEC_W(VEC_W)) u_arb (
      .req (req),
      .any (any),
      .win (win)
   );

   logic still_wanted;
   assign still_wanted = gie_q & req[vec_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else if (accept) begin
         irq_q <= 1'b0;
      end else if (irq_q) begin
         if (!still_wanted) irq_q <= 1'b0;
      end else if (gie_q && any) begin
         irq_q <= 1'b1;
         vec_q <= win;
      end
   end

   assign irq_out    = irq_q;
   assign vector_out = vec_q;

   // ---------------- checks ----------------
   assert_vec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack) |=> (!irq_q || vec_q == $past(vec_q)));
   assert_ack_drops_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!gie_q && !irq_q));
   assert_reti_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !accept) |=> gie_q);
   assert_issue_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(gie_q));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
   localparam int NI = 11;
   localparam int NE = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] ext_irq = '0;
   logic [NI-1:0] periph_evt = '0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_wdata = '0;
   logic          ack = 1'b0;
   logic          reti = 1'b0;
   logic          irq_out;
   logic [3:0]    vector_out;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   vec_irq_ctrl u_vec_irq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_irq    (ext_irq),
      .periph_evt (periph_evt),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .ack        (ack),
      .reti       (reti),
      .irq_out    (irq_out),
      .vector_out (vector_out)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic expect_out(input string tag, input int e_irq, input int e_vec);
      chk(irq_out == e_irq[0], {tag, " irq_out"}, int'(irq_out), e_irq);
      if (e_irq != 0) chk(int'(vector_out) == e_vec, {tag, " vector_out"}, int'(vector_out), e_vec);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ext_irq = '0; periph_evt = '0; cfg_we = 1'b0; ack = 1'b0; reti = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic set_cfg(input bit g, input logic [4:0] grp);
      cfg_we = 1'b1; cfg_wdata = {grp, g};
      step();
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NI-1:0] bits);
      periph_evt = bits;
      step();
      periph_evt = '0;
   endtask

   task automatic do_ack();
      ack = 1'b1; step(); ack = 1'b0;
   endtask

   task automatic do_reti();
      reti = 1'b1; step(); reti = 1'b0;
   endtask

   function automatic int group_of(input int v);
      if (v <= 2)  return 0;
      if (v <= 8)  return 1;
      if (v == 9)  return 2;
      if (v <= 12) return 3;
      return 4;
   endfunction

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state and reset clearing a latched event
      do_reset();
      expect_out("R1", 0, 0);
      chk(vector_out == 4'd0, "R1 vector at reset", int'(vector_out), 0);
      pulse(NI'(1) << 1);
      do_reset();
      set_cfg(1'b1, 5'h1f);
      step(); step();
      expect_out("R1 pending cleared", 0, 0);

      // R2, R5: each internal source alone
      for (int k = 0; k < NI; k++) begin
         do_reset();
         set_cfg(1'b1, 5'h1f);
         pulse(NI'(1) << k);
         expect_out("R2 one edge", 0, 0);
         step();
         expect_out("R2 issue", 1, k + 3);
         do_ack();
         expect_out("R5 ack drop", 0, 0);
         step();
         expect_out("R5 gie off", 0, 0);
         do_reti();
         step();
         expect_out("R5 flag cleared", 0, 0);
      end

      // R3, R6: every ordered pair raised together while disabled
      for (int a = 0; a < NI; a++) begin
         for (int b = 0; b < NI; b++) begin
            if (a != b) begin
               do_reset();
               set_cfg(1'b0, 5'h1f);
               pulse((NI'(1) << a) | (NI'(1) << b));
               step();
               expect_out("R6 held while off", 0, 0);
               do_reti();
               step();
               expect_out("R3 winner", 1, ((a < b) ? a : b) + 3);
               do_ack();
               do_reti();
               step();
               expect_out("R6 second in order", 1, ((a < b) ? b : a) + 3);
               do_ack();
               do_reti();
               step();
               expect_out("R6 drained", 0, 0);
            end
         end
      end

      // R9: own group masked, then unmasked
      for (int k = 0; k < NI; k++) begin
         do_reset();
         set_cfg(1'b1, 5'h1f & ~(5'(1) << group_of(k + 3)));
         pulse(NI'(1) << k);
         step(); step();
         expect_out("R9 masked", 0, 0);
         set_cfg(1'b1, 5'h1f);
         step();
         expect_out("R9 unmasked", 1, k + 3);
      end
      do_reset();
      set_cfg(1'b1, 5'h1e);
      ext_irq = 2'b01;
      step(); step(); step(); step();
      expect_out("R9 pins masked", 0, 0);
      ext_irq = 2'b00;

      // R8: synchronized level pins
      do_reset();
      set_cfg(1'b1, 5'h1f);
      ext_irq = 2'b01;
      step();
      expect_out("R8 sync 1", 0, 0);
      step();
      expect_out("R8 sync 2", 0, 0);
      step();
      expect_out("R8 pin issue", 1, 1);
      ext_irq = 2'b00;
      step(); step();
      expect_out("R8 still shown", 1, 1);
      step();
      expect_out("R8 withdrawn", 0, 0);
      step(); step(); step();
      expect_out("R8 lost", 0, 0);
      ext_irq = 2'b11;
      step(); step(); step();
      expect_out("R8 both pins", 1, 1);
      do_ack();
      ext_irq = 2'b10;
      step(); step();
      do_reti();
      step();
      expect_out("R8 second pin", 1, 2);
      ext_irq = 2'b00;

      // R4: vector held against a higher arrival
      do_reset();
      set_cfg(1'b1, 5'h1f);
      pulse(NI'(1) << 7);
      step();
      expect_out("R4 first", 1, 10);
      pulse(NI'(1) << 0);
      step(); step();
      expect_out("R4 held", 1, 10);
      do_ack();
      do_reti();
      step();
      expect_out("R4 higher next", 1, 3);

      // R10: event coinciding with its own ack
      do_reset();
      set_cfg(1'b1, 5'h1f);
      pulse(NI'(1) << 4);
      step();
      expect_out("R10 first", 1, 7);
      periph_evt = NI'(1) << 4;
      ack = 1'b1;
      step();
      periph_evt = '0;
      ack = 1'b0;
      expect_out("R10 accepted", 0, 0);
      do_reti();
      step();
      expect_out("R10 reissued", 1, 7);

      // R7: nested enable written inside a handler
      do_reset();
      set_cfg(1'b1, 5'h1f);
      pulse(NI'(1) << 8);
      step();
      expect_out("R7 outer", 1, 11);
      do_ack();
      pulse(NI'(1) << 2);
      step();
      expect_out("R7 off in handler", 0, 0);
      set_cfg(1'b1, 5'h1f);
      step();
      expect_out("R7 nested", 1, 5);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule